// File: doc/BRIEF.md
# Data-Strobe Serial Link Codec

This block sits between a link controller and one cable port of a bus that signals with a data line and a strobe line. On the transmit side it takes parallel words from the link controller and shifts them out one bit at a time, most significant bit first. The data line carries each bit. The strobe line toggles whenever the bit repeats the previous data value, so exactly one of the two lines changes per bit. In low-speed mode a word is two bits wide and each bit lasts `CYC_LO` clocks. In double-speed mode a word is four bits wide and each bit lasts half as long. A new word is therefore taken every `2*CYC_LO` clocks in either mode.

On the receive side the block samples the incoming data and strobe lines through a synchronizer into the internal clock domain. Every change of data XOR strobe marks one bit, and the value of that bit is the data line. The recovered bits are grouped into 2-bit or 4-bit words. Each word is presented with a one-cycle valid pulse.

The speed is sampled when a packet starts and is held until that packet ends. While the port drives the lines, the receiver ignores them.

Top module: `ds_link_codec`

## Requirements
- R1: After reset, `dataOut`, `strobeOut`, `drvEnable`, `txTake` and `rxValid` are all low.
- R2: For every transmitted bit, exactly one line changes. `dataOut` becomes the bit value. `strobeOut` toggles if and only if the bit equals the previous `dataOut` value.
- R3: A packet starts at the first clock edge at which `txActive` is high while idle. At that edge the word is taken, `txTake` pulses for one cycle, `drvEnable` rises and the first bit appears. Bits go out MSB first. In low mode each bit lasts `CYC_LO` clocks and the word is taken from `txWord[1:0]`. In high mode each bit lasts `CYC_LO/2` clocks and the word is taken from `txWord[3:0]`. A new word is taken every `2*CYC_LO` clocks.
- R4: `txActive` is sampled at each word boundary. If it is low there, `drvEnable` falls at that edge and both lines hold their last values.
- R5: `speedHi` is latched at the start of each transmit packet and at the rise of `rxActive`. Changes to `speedHi` during a packet have no effect.
- R6: Each change of data XOR strobe on the synchronized inputs is one received bit, whose value is the data line. The first change after `rxActive` rises is the MSB of the first word, and a partial word from an earlier packet is discarded.
- R7: After 2 bits (low mode) or 4 bits (high mode), `rxWord` carries the word with the first bit as its MSB, together with a `rxValid` pulse that lasts one cycle. In low mode `rxWord[3:2]` are zero.
- R8: While `drvEnable` is high, changes on `dataIn`/`strobeIn` produce no `rxValid` and do not count toward a word.
- R9: Bits are recovered correctly when consecutive line changes are as little as one clock apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Active-low synchronous reset |
| speedHi | input | 1 | Speed select: 1 = double speed, 4-bit words |
| txActive | input | 1 | Transmit packet request, sampled at word boundaries |
| txWord | input | 4 | Parallel word to transmit |
| txTake | output | 1 | One-cycle pulse: `txWord` was taken at the previous edge |
| dataOut | output | 1 | Transmit data line |
| strobeOut | output | 1 | Transmit strobe line |
| drvEnable | output | 1 | Line drivers enabled; the receiver is disabled while high |
| rxActive | input | 1 | Receive packet window |
| dataIn | input | 1 | Received data line (asynchronous) |
| strobeIn | input | 1 | Received strobe line (asynchronous) |
| rxWord | output | 4 | Received parallel word |
| rxValid | output | 1 | One-cycle pulse marking `rxWord` |

## Verification
The bench sends runs of repeated bits, so a design that toggled the wrong line on a repeat would produce a strobe mismatch. It flips `speedHi` in the middle of both transmit and receive packets; a design that did not latch the speed would change the bit period or the word width partway through a packet. It drives receive bits one clock apart and injects line toggles while the port is driving; a design that lost bits at that spacing, or counted bits while transmitting, would deliver misaligned words. It also leaves a stray partial word before a new receive packet and sends a packet of a single word, to catch a bit count that is not cleared on a new packet and a transmitter that stops mid-word.

// File: rtl/ds_codec_pkg.sv
package ds_codec_pkg;
  localparam int WORD_HI = 4;
  localparam int WORD_LO = 2;

  typedef struct packed {
    logic load;
    logic shift;
    logic hiMode;
  } txStrobe_t;
endpackage

// File: rtl/ds_tx_ctrl.sv
module ds_tx_ctrl
  import ds_codec_pkg::*;
#(
  parameter int CYC_LO = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txActive,
  input  logic       speedHi,
  output txStrobe_t  strb,
  output logic       drvEnable,
  output logic       txTake
);
  localparam int CYC_HI = CYC_LO / 2;
  localparam int TW = $clog2(CYC_LO);
  localparam int BW = $clog2(WORD_HI);

  logic          speedQ;
  logic [TW-1:0] timer;
  logic [BW-1:0] bitIdx;
  logic          lastTick, lastBit, start;

  assign lastTick = (timer == (speedQ ? TW'(CYC_HI - 1) : TW'(CYC_LO - 1)));
  assign lastBit  = (bitIdx == (speedQ ? BW'(WORD_HI - 1) : BW'(WORD_LO - 1)));
  assign start    = !drvEnable && txActive;

  always_comb begin
    strb.load   = start || (drvEnable && lastTick && lastBit && txActive);
    strb.shift  = drvEnable && lastTick && !lastBit;
    strb.hiMode = start ? speedHi : speedQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      drvEnable <= 1'b0;
      speedQ    <= 1'b0;
      timer     <= '0;
      bitIdx    <= '0;
      txTake    <= 1'b0;
    end else begin
      txTake <= strb.load;
      if (start) begin
        drvEnable <= 1'b1;
        speedQ    <= speedHi;
        timer     <= '0;
        bitIdx    <= '0;
      end else if (drvEnable) begin
        if (lastTick) begin
          timer <= '0;
          if (lastBit) begin
            bitIdx <= '0;
            if (!txActive) drvEnable <= 1'b0;
          end else begin
            bitIdx <= bitIdx + 1'b1;
          end
        end else begin
          timer <= timer + 1'b1;
        end
      end
    end
  end

  p_take_driving_r3: assert property (@(posedge clk) disable iff (!rstN)
    txTake |-> drvEnable);

  p_speed_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (drvEnable && $past(drvEnable)) |-> $stable(speedQ));
endmodule

// File: rtl/ds_tx_datapath.sv
module ds_tx_datapath
  import ds_codec_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  txStrobe_t          strb,
  input  logic [WORD_HI-1:0] txWord,
  output logic               dataOut,
  output logic               strobeOut
);
  logic [WORD_HI-1:0] shreg, loadVec;
  logic               nextBit;

  always_comb begin
    loadVec = strb.hiMode ? txWord
                          : {txWord[WORD_LO-1:0], {(WORD_HI-WORD_LO){1'b0}}};
    nextBit = strb.load ? loadVec[WORD_HI-1] : shreg[WORD_HI-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shreg     <= '0;
      dataOut   <= 1'b0;
      strobeOut <= 1'b0;
    end else begin
      if (strb.load)       shreg <= loadVec << 1;
      else if (strb.shift) shreg <= shreg << 1;
      if (strb.load || strb.shift) begin
        dataOut   <= nextBit;
        strobeOut <= strobeOut ^ (nextBit == dataOut);
      end
    end
  end

  p_one_line_r2: assert property (@(posedge clk) disable iff (!rstN)
    $countones({dataOut ^ $past(dataOut), strobeOut ^ $past(strobeOut)}) <= 1);
endmodule

// File: rtl/ds_rx_path.sv
module ds_rx_path
  import ds_codec_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               dataIn,
  input  logic               strobeIn,
  input  logic               rxActive,
  input  logic               speedHi,
  input  logic               drvEnable,
  output logic [WORD_HI-1:0] rxWord,
  output logic               rxValid
);
  localparam int BW = $clog2(WORD_HI);

  logic [SYNC_STAGES-1:0] dSync, sSync;
  logic                   dNow, sNow, parQ, rxActQ, rxSpeedQ;
  logic                   rise, spd, bitEdge, take;
  logic [BW-1:0]          cnt, cntBase;
  logic [WORD_HI-1:0]     shreg, shNext;

  assign dNow    = dSync[SYNC_STAGES-1];
  assign sNow    = sSync[SYNC_STAGES-1];
  assign rise    = rxActive && !rxActQ;
  assign spd     = rise ? speedHi : rxSpeedQ;
  assign bitEdge = (dNow ^ sNow) != parQ;
  assign take    = bitEdge && rxActive && !drvEnable;
  assign cntBase = rise ? '0 : cnt;
  assign shNext  = {shreg[WORD_HI-2:0], dNow};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dSync    <= '0;
      sSync    <= '0;
      parQ     <= 1'b0;
      rxActQ   <= 1'b0;
      rxSpeedQ <= 1'b0;
      cnt      <= '0;
      shreg    <= '0;
      rxWord   <= '0;
      rxValid  <= 1'b0;
    end else begin
      dSync   <= {dSync[SYNC_STAGES-2:0], dataIn};
      sSync   <= {sSync[SYNC_STAGES-2:0], strobeIn};
      parQ    <= dNow ^ sNow;
      rxActQ  <= rxActive;
      rxValid <= 1'b0;
      if (rise) rxSpeedQ <= speedHi;
      if (take) begin
        shreg <= shNext;
        if (cntBase == (spd ? BW'(WORD_HI - 1) : BW'(WORD_LO - 1))) begin
          cnt     <= '0;
          rxValid <= 1'b1;
          rxWord  <= spd ? shNext
                         : {{(WORD_HI-WORD_LO){1'b0}}, shNext[WORD_LO-1:0]};
        end else begin
          cnt <= cntBase + 1'b1;
        end
      end else begin
        cnt <= cntBase;
      end
    end
  end

  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  p_quiet_drive_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(drvEnable) |-> !rxValid);
endmodule

// File: rtl/ds_link_codec.sv
module ds_link_codec
  import ds_codec_pkg::*;
#(
  parameter int CYC_LO      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       speedHi,
  input  logic       txActive,
  input  logic [3:0] txWord,
  output logic       txTake,
  output logic       dataOut,
  output logic       strobeOut,
  output logic       drvEnable,
  input  logic       rxActive,
  input  logic       dataIn,
  input  logic       strobeIn,
  output logic [3:0] rxWord,
  output logic       rxValid
);
  txStrobe_t txStrb;

  ds_tx_ctrl #(.CYC_LO(CYC_LO)) u_ctrl (
    .clk(clk), .rstN(rstN), .txActive(txActive), .speedHi(speedHi),
    .strb(txStrb), .drvEnable(drvEnable), .txTake(txTake)
  );

  ds_tx_datapath u_txdp (
    .clk(clk), .rstN(rstN), .strb(txStrb), .txWord(txWord),
    .dataOut(dataOut), .strobeOut(strobeOut)
  );

  ds_rx_path #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .strobeIn(strobeIn),
    .rxActive(rxActive), .speedHi(speedHi), .drvEnable(drvEnable),
    .rxWord(rxWord), .rxValid(rxValid)
  );
endmodule

// File: tb/ds_link_codec_test.sv
`timescale 1ns/1ps
module ds_link_codec_test;
  logic clk = 0, rstN = 0, speedHi = 0, txActive = 0, rxActive = 0;
  logic dataIn = 0, strobeIn = 0;
  logic [3:0] txWord = 0;
  logic txTake, dataOut, strobeOut, drvEnable, rxValid;
  logic [3:0] rxWord;

  int checks = 0, errors = 0;
  logic [3:0] expW [0:255];
  int expCnt = 0, gotCnt = 0;
  logic lineD = 0, lineS = 0;
  int seedDummy;

  always #2 clk = ~clk;

  ds_link_codec uut (
    .clk(clk), .rstN(rstN), .speedHi(speedHi), .txActive(txActive),
    .txWord(txWord), .txTake(txTake), .dataOut(dataOut), .strobeOut(strobeOut),
    .drvEnable(drvEnable), .rxActive(rxActive), .dataIn(dataIn),
    .strobeIn(strobeIn), .rxWord(rxWord), .rxValid(rxValid)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Receive monitor (R7, R8)
  always @(negedge clk) begin
    if (rstN && rxValid) begin
      if (gotCnt < expCnt)
        check(rxWord == expW[gotCnt], "R7", "rx word", rxWord, expW[gotCnt]);
      else
        check(1'b0, "R8", "unexpected rxValid", rxWord, 0);
      gotCnt++;
    end
  end

  function automatic logic expStrobe(input logic bitV, input logic pd, input logic ps);
    return ps ^ (bitV == pd);
  endfunction

  task automatic sendPacket(input bit hi, input int nWords, input bit flip);
    int p = hi ? 2 : 4;
    int bw = hi ? 4 : 2;
    logic [3:0] cur, nxt;
    logic pd, ps, eb, es;
    @(negedge clk);
    pd = dataOut; ps = strobeOut;
    cur = 4'($urandom); nxt = cur;
    speedHi = hi; txActive = 1; txWord = cur;
    for (int i = 0; i < nWords; i++) begin
      for (int k = 0; k < bw; k++) begin
        if (i == 0 && k == 0) @(negedge clk);
        else repeat (p) @(negedge clk);
        eb = cur[bw-1-k];
        es = expStrobe(eb, pd, ps);
        check(dataOut == eb, "R3", "tx data bit", dataOut, eb);
        check(strobeOut == es, "R2", "tx strobe", strobeOut, es);
        check(txTake == (k == 0), "R3", "txTake", txTake, k == 0);
        if (k == 0) check(drvEnable == 1'b1, "R4", "drvEnable in packet", drvEnable, 1);
        pd = eb; ps = es;
        if (k == 0) begin
          if (i < nWords - 1) begin nxt = 4'($urandom); txWord = nxt; end
          else txActive = 0;
        end
        if (k == 1 && flip) speedHi = ~hi;   // R5: must not matter
        if (k == bw - 1) cur = nxt;
      end
    end
    repeat (p) @(negedge clk);
    check(drvEnable == 1'b0, "R4", "drvEnable after end", drvEnable, 0);
    check(dataOut == pd, "R4", "data holds", dataOut, pd);
    check(strobeOut == ps, "R4", "strobe holds", strobeOut, ps);
    check(txTake == 1'b0, "R4", "no take after end", txTake, 0);
  endtask

  task automatic driveBit(input logic b);
    if (b == lineD) lineS = ~lineS; else lineD = b;
    dataIn = lineD; strobeIn = lineS;
  endtask

  task automatic rxSend(input bit hi, input int nWords, input int maxGap,
                        input bit flip, input string req);
    int bw = hi ? 4 : 2;
    logic [3:0] w;
    @(negedge clk);
    speedHi = hi; rxActive = 1;
    @(negedge clk);
    if (flip) speedHi = ~hi;                 // R5: must not matter
    for (int i = 0; i < nWords; i++) begin
      w = 4'($urandom);
      if (!hi) w[3:2] = 2'b00;
      expW[expCnt] = w; expCnt++;
      for (int k = 0; k < bw; k++) begin
        driveBit(w[bw-1-k]);
        repeat (1 + $urandom_range(maxGap - 1)) @(negedge clk);
      end
    end
    repeat (6) @(negedge clk);
    check(gotCnt == expCnt, req, "rx word count", gotCnt, expCnt);
    rxActive = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    seedDummy = $urandom(32'h1394);
    repeat (3) @(negedge clk);
    // R1: reset state
    check(dataOut == 0, "R1", "dataOut reset", dataOut, 0);
    check(strobeOut == 0, "R1", "strobeOut reset", strobeOut, 0);
    check(drvEnable == 0, "R1", "drvEnable reset", drvEnable, 0);
    check(txTake == 0, "R1", "txTake reset", txTake, 0);
    check(rxValid == 0, "R1", "rxValid reset", rxValid, 0);
    rstN = 1;
    repeat (2) @(negedge clk);

    // Directed transmit: repeated bits, single-word packet, speed flips
    txWord = 4'hF;
    sendPacket(1'b1, 1, 1'b0);
    sendPacket(1'b0, 3, 1'b1);
    sendPacket(1'b1, 2, 1'b1);
    // Random transmit
    for (int r = 0; r < 8; r++)
      sendPacket(1'($urandom), 1 + $urandom_range(3), 1'($urandom));

    // Receive: R6 basic, R9 one-clock spacing, R5 flip
    rxSend(1'b0, 3, 3, 1'b0, "R6");
    rxSend(1'b1, 3, 1, 1'b0, "R9");
    rxSend(1'b0, 4, 1, 1'b1, "R5");
    rxSend(1'b1, 3, 4, 1'b1, "R5");

    // R6: stray partial word discarded on new packet
    @(negedge clk); speedHi = 1; rxActive = 1;
    @(negedge clk); driveBit(1'b1);
    repeat (5) @(negedge clk); rxActive = 0;
    repeat (2) @(negedge clk);
    rxSend(1'b1, 2, 2, 1'b0, "R6");

    // R8: toggles while driving are ignored
    @(negedge clk); speedHi = 0; rxActive = 1;
    fork
      sendPacket(1'b1, 3, 1'b0);
      begin
        repeat (4) @(negedge clk);
        for (int t = 0; t < 10; t++) begin
          lineD = ~lineD; dataIn = lineD;
          @(negedge clk);
        end
      end
    join
    repeat (4) @(negedge clk);
    check(gotCnt == expCnt, "R8", "no words while driving", gotCnt, expCnt);
    rxSend(1'b0, 2, 3, 1'b0, "R8");

    // Random receive
    for (int r = 0; r < 6; r++)
      rxSend(1'($urandom), 1 + $urandom_range(3), 1 + $urandom_range(3), 1'($urandom), "R7");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule